// File: doc/BRIEF.md
# Boot mode configuration gate

This block decides how an embedded processor that sits behind a PCI target comes out of reset. A 2-bit strap pair selects one of four boot modes. The selected mode sets two policies. The first is whether the processor core is held in reset. The second is whether PCI type-0 configuration cycles addressed to the device are accepted or turned away with Retry. Each policy has its own bit in a small control register, and clearing that bit lifts the policy.

The control register has two write ports. The host writes it over PCI, and the local core writes it over the local bus. A host write is itself a configuration access, so it is only taken while configuration cycles are being accepted. A core write is only taken while the core is running. Setting a third bit in the register resets the local-bus peripherals for a fixed number of cycles and leaves the core alone.

A strap pair left floating is pulled up and reads 2'b11. That value is the fenced auto-start mode, which is the normal setting.

Top module: `boot_mode_gate`

## Requirements
- R1: The strap value is captured on every clock edge while `rst` is high. The value from the last such edge is held from then on, and later changes on `strap_i` have no effect until the next reset.
- R2: Strap value 0 (host-configured boot): configuration cycles are accepted, and `core_reset_n` stays low until a host write clears control bit 1.
- R3: Strap value 1 (locked boot): every configuration cycle gets Retry and `core_reset_n` stays low, whatever is written to the control register.
- R4: Strap value 2 (open auto-start): `core_reset_n` is high straight after reset and configuration cycles are accepted.
- R5: Strap value 3 (fenced auto-start): `core_reset_n` is high straight after reset, and configuration cycles get Retry until a core write clears control bit 2.
- R6: Each clock cycle with `cfg_strobe` high produces exactly one of `cfg_retry` or `cfg_accept`, high for one cycle, on the cycle after the strobe. With no strobe, neither output is high.
- R7: A host write is discarded while configuration cycles get Retry. A core write is discarded while `core_reset_n` is low.
- R8: Writing 1 to control bit 5 drives `local_bus_reset` high for exactly PULSE_LEN (default 16) cycles, starting on the cycle after the write, and `core_reset_n` does not change. A new such write during the pulse restarts the full length.
- R9: Straight after reset the register reads with bit 1 = 1 in modes 0 and 1, and with bit 2 = 1 in modes 1 and 3. `ctrl_rdata` shows bit 1 (core hold), bit 2 (configuration fence) and bit 5 (pulse active). All other bits read 0.
- R10: When the host and the core both write in the same cycle and both writes are acceptable, the core's data is taken.
- R11: A write that sets any bit other than 1, 2 or 5 is discarded whole.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous system reset, active high |
| strap_i | input | 2 | Boot mode strap value |
| cfg_strobe | input | 1 | One cycle per incoming configuration cycle |
| host_wr | input | 1 | Host write to the control register |
| host_wdata | input | CTRL_W | Host write data |
| core_wr | input | 1 | Local core write to the control register |
| core_wdata | input | CTRL_W | Local core write data |
| core_reset_n | output | 1 | Core reset, active low |
| cfg_retry | output | 1 | Answer the configuration cycle with Retry |
| cfg_accept | output | 1 | Accept the configuration cycle |
| local_bus_reset | output | 1 | Reset pulse to the local-bus peripherals |
| ctrl_rdata | output | CTRL_W | Control register read value |

## Verification
A configuration response is due on the cycle after its strobe. A register write changes `ctrl_rdata` and `core_reset_n` on the cycle after the write. The reset pulse is high from the cycle after the write, for PULSE_LEN cycles. The bench drives each stimulus on a falling edge and samples on the next falling edge, so every result is read one rising edge after its cause. For the reset pulse, the bench counts the consecutive high samples at falling edges and compares the count with the expected length, which is 16 for a single write and 21 for a write that lands on the fifth high cycle of a running pulse.

// File: rtl/boot_gate_pkg.sv
package boot_gate_pkg;

    localparam int STRAP_W   = 2;
    localparam int HOLD_BIT  = 1;
    localparam int FENCE_BIT = 2;
    localparam int LBRST_BIT = 5;

    typedef enum logic [STRAP_W-1:0] {
        BOOT_HOSTCFG     = 2'd0,
        BOOT_LOCKED      = 2'd1,
        BOOT_AUTO_OPEN   = 2'd2,
        BOOT_AUTO_FENCED = 2'd3
    } boot_mode_e;

    typedef struct packed {
        logic hold;
        logic fence;
    } boot_ctl_s;

    function automatic boot_mode_e decode_strap(input logic [STRAP_W-1:0] s);
        return boot_mode_e'(s);
    endfunction

    function automatic boot_ctl_s reset_ctl(input boot_mode_e m);
        boot_ctl_s c;
        c.hold  = (m == BOOT_HOSTCFG) || (m == BOOT_LOCKED);
        c.fence = (m == BOOT_LOCKED)  || (m == BOOT_AUTO_FENCED);
        return c;
    endfunction

endpackage

// File: rtl/boot_strap_latch.sv
module boot_strap_latch
    import boot_gate_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [STRAP_W-1:0] strap_i,
    output boot_mode_e         mode_o
);
    boot_mode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= decode_strap(strap_i);
        end
    end

    assign mode_o = mode_q;

    assert_strap_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(mode_q));

endmodule

// File: rtl/boot_ctrl_reg.sv
module boot_ctrl_reg
    import boot_gate_pkg::*;
#(
    parameter int CTRL_W = 8
)(
    input  logic               clk,
    input  logic               rst,
    input  logic [STRAP_W-1:0] strap_i,
    input  boot_mode_e         mode_i,
    input  logic               host_wr,
    input  logic [CTRL_W-1:0]  host_wdata,
    input  logic               core_wr,
    input  logic [CTRL_W-1:0]  core_wdata,
    input  logic               lbrst_busy,
    output logic               core_held,
    output logic               cfg_blocked,
    output logic               lbrst_trig,
    output logic [CTRL_W-1:0]  rdata
);
    localparam logic [CTRL_W-1:0] FUNC_MASK =
        (CTRL_W'(1) << HOLD_BIT) | (CTRL_W'(1) << FENCE_BIT) | (CTRL_W'(1) << LBRST_BIT);

    boot_ctl_s         ctl_q;
    logic              host_clean, core_clean;
    logic              core_ok, host_ok, wr_en;
    logic [CTRL_W-1:0] wsel;

    // Mode 1 pins both policies regardless of the stored bits.
    always_comb begin
        core_held   = ctl_q.hold  | (mode_i == BOOT_LOCKED);
        cfg_blocked = ctl_q.fence | (mode_i == BOOT_LOCKED);
    end

    always_comb begin
        host_clean = ((host_wdata & ~FUNC_MASK) == '0);
        core_clean = ((core_wdata & ~FUNC_MASK) == '0);
        core_ok    = core_wr & ~core_held & core_clean;
        host_ok    = host_wr & ~cfg_blocked & host_clean & ~core_ok;
        wr_en      = core_ok | host_ok;
        wsel       = core_ok ? core_wdata : host_wdata;
        lbrst_trig = wr_en & wsel[LBRST_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= reset_ctl(decode_strap(strap_i));
        end else if (wr_en) begin
            ctl_q.hold  <= wsel[HOLD_BIT];
            ctl_q.fence <= wsel[FENCE_BIT];
        end
    end

    always_comb begin
        rdata            = '0;
        rdata[HOLD_BIT]  = ctl_q.hold;
        rdata[FENCE_BIT] = ctl_q.fence;
        rdata[LBRST_BIT] = lbrst_busy;
    end

    assert_core_lockout_R7: assert property (@(posedge clk) disable iff (rst)
        (core_wr && core_held && !host_wr) |=> $stable(ctl_q));

    assert_host_lockout_R7: assert property (@(posedge clk) disable iff (rst)
        (host_wr && cfg_blocked && !core_wr) |=> $stable(ctl_q));

    assert_reserved_reject_R11: assert property (@(posedge clk) disable iff (rst)
        (!host_clean && !core_clean) |=> $stable(ctl_q));

endmodule

// File: rtl/boot_cfg_responder.sv
module boot_cfg_responder (
    input  logic clk,
    input  logic rst,
    input  logic strobe_i,
    input  logic blocked_i,
    output logic retry_o,
    output logic accept_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            retry_o  <= 1'b0;
            accept_o <= 1'b0;
        end else begin
            retry_o  <= strobe_i & blocked_i;
            accept_o <= strobe_i & ~blocked_i;
        end
    end

    assert_one_response_R6: assert property (@(posedge clk) disable iff (rst)
        strobe_i |=> (retry_o ^ accept_o));

    assert_no_spurious_R6: assert property (@(posedge clk) disable iff (rst)
        !strobe_i |=> !(retry_o || accept_o));

endmodule

// File: rtl/boot_lbus_pulse.sv
module boot_lbus_pulse #(
    parameter int PULSE_LEN = 16
)(
    input  logic clk,
    input  logic rst,
    input  logic trig_i,
    output logic pulse_o
);
    localparam int CNT_W = $clog2(PULSE_LEN + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (trig_i) begin
            cnt_q <= CNT_W'(PULSE_LEN);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign pulse_o = (cnt_q != '0);

    // Checker: length of the high run since the last trigger.
    logic [CNT_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst || trig_i) begin
            run_q <= '0;
        end else if (pulse_o) begin
            run_q <= run_q + 1'b1;
        end
    end

    assert_pulse_length_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(pulse_o) |-> (run_q == CNT_W'(PULSE_LEN)));

endmodule

// File: rtl/boot_mode_gate.sv
module boot_mode_gate
    import boot_gate_pkg::*;
#(
    parameter int CTRL_W    = 8,
    parameter int PULSE_LEN = 16
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        strap_i,
    input  logic              cfg_strobe,
    input  logic              host_wr,
    input  logic [CTRL_W-1:0] host_wdata,
    input  logic              core_wr,
    input  logic [CTRL_W-1:0] core_wdata,
    output logic              core_reset_n,
    output logic              cfg_retry,
    output logic              cfg_accept,
    output logic              local_bus_reset,
    output logic [CTRL_W-1:0] ctrl_rdata
);
    boot_mode_e mode;
    logic       core_held, cfg_blocked, lbrst_trig;

    boot_strap_latch u_strap (
        .clk     (clk),
        .rst     (rst),
        .strap_i (strap_i),
        .mode_o  (mode)
    );

    boot_ctrl_reg #(.CTRL_W(CTRL_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .strap_i     (strap_i),
        .mode_i      (mode),
        .host_wr     (host_wr),
        .host_wdata  (host_wdata),
        .core_wr     (core_wr),
        .core_wdata  (core_wdata),
        .lbrst_busy  (local_bus_reset),
        .core_held   (core_held),
        .cfg_blocked (cfg_blocked),
        .lbrst_trig  (lbrst_trig),
        .rdata       (ctrl_rdata)
    );

    boot_cfg_responder u_resp (
        .clk       (clk),
        .rst       (rst),
        .strobe_i  (cfg_strobe),
        .blocked_i (cfg_blocked),
        .retry_o   (cfg_retry),
        .accept_o  (cfg_accept)
    );

    boot_lbus_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk     (clk),
        .rst     (rst),
        .trig_i  (lbrst_trig),
        .pulse_o (local_bus_reset)
    );

    assign core_reset_n = ~core_held;

    assert_locked_mode_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == BOOT_LOCKED) |-> (!core_reset_n && !cfg_accept));

    assert_pulse_spares_core_R8: assert property (@(posedge clk) disable iff (rst)
        (local_bus_reset && !core_wr && !host_wr) |=> $stable(core_reset_n));

endmodule

// File: tb/test_boot_mode_gate.sv
module test_boot_mode_gate;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   strap = 2'd3;
    logic         strobe = 1'b0;
    logic         host_wr = 1'b0;
    logic [W-1:0] host_wdata = '0;
    logic         core_wr = 1'b0;
    logic [W-1:0] core_wdata = '0;
    logic         core_reset_n, cfg_retry, cfg_accept, local_bus_reset;
    logic [W-1:0] ctrl_rdata;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    boot_mode_gate i_boot_mode_gate (
        .clk(clk), .rst(rst), .strap_i(strap), .cfg_strobe(strobe),
        .host_wr(host_wr), .host_wdata(host_wdata),
        .core_wr(core_wr), .core_wdata(core_wdata),
        .core_reset_n(core_reset_n), .cfg_retry(cfg_retry), .cfg_accept(cfg_accept),
        .local_bus_reset(local_bus_reset), .ctrl_rdata(ctrl_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] s);
        @(negedge clk);
        strap = s;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic probe(input string tag, input bit exp_retry);
        strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        chk({tag, " retry"}, {31'd0, cfg_retry}, {31'd0, exp_retry});
        chk({tag, " accept"}, {31'd0, cfg_accept}, {31'd0, !exp_retry});
        @(negedge clk);
        chk("R6 response lasts one cycle", {30'd0, cfg_retry, cfg_accept}, 32'd0);
    endtask

    task automatic host_write(input logic [W-1:0] d);
        host_wr = 1'b1; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic core_write(input logic [W-1:0] d);
        core_wr = 1'b1; core_wdata = d;
        @(negedge clk);
        core_wr = 1'b0;
    endtask

    task automatic t_mode0;
        do_reset(2'd0);
        chk("R9 mode0 reset image", {24'd0, ctrl_rdata}, 32'h02);
        chk("R2 mode0 core held", {31'd0, core_reset_n}, 32'd0);
        probe("R2 mode0 cfg", 1'b0);
        host_write(8'h00);
        chk("R2 mode0 host release", {31'd0, core_reset_n}, 32'd1);
    endtask

    task automatic t_mode1;
        do_reset(2'd1);
        chk("R9 mode1 reset image", {24'd0, ctrl_rdata}, 32'h06);
        chk("R3 mode1 core held", {31'd0, core_reset_n}, 32'd0);
        probe("R3 mode1 cfg", 1'b1);
        host_write(8'h00);
        chk("R7 mode1 host write ignored", {24'd0, ctrl_rdata}, 32'h06);
        core_write(8'h00);
        chk("R7 mode1 core write ignored", {24'd0, ctrl_rdata}, 32'h06);
        chk("R3 mode1 still held", {31'd0, core_reset_n}, 32'd0);
        probe("R3 mode1 cfg after writes", 1'b1);
    endtask

    task automatic t_mode2;
        do_reset(2'd2);
        chk("R9 mode2 reset image", {24'd0, ctrl_rdata}, 32'h00);
        chk("R4 mode2 core runs", {31'd0, core_reset_n}, 32'd1);
        probe("R4 mode2 cfg", 1'b0);
        host_write(8'h84);
        chk("R11 reserved bit write dropped", {24'd0, ctrl_rdata}, 32'h00);
        host_write(8'h04);
        probe("R7 fence set by host", 1'b1);
        host_write(8'h00);
        chk("R7 host write ignored when fenced", {24'd0, ctrl_rdata}, 32'h04);
        core_write(8'h00);
        probe("R7 core clears fence", 1'b0);
    endtask

    task automatic t_mode3;
        do_reset(2'd3);
        chk("R9 mode3 reset image", {24'd0, ctrl_rdata}, 32'h04);
        chk("R5 mode3 core runs", {31'd0, core_reset_n}, 32'd1);
        probe("R5 mode3 cfg fenced", 1'b1);
        host_write(8'h00);
        probe("R7 mode3 host cannot unfence", 1'b1);
        core_write(8'h00);
        probe("R5 mode3 core unfenced", 1'b0);
    endtask

    task automatic t_strap_hold;
        do_reset(2'd3);
        strap = 2'd0;
        repeat (4) @(negedge clk);
        chk("R1 core unaffected by strap change", {31'd0, core_reset_n}, 32'd1);
        probe("R1 fence unaffected by strap change", 1'b1);
    endtask

    task automatic t_priority;
        do_reset(2'd2);
        host_wr = 1'b1; host_wdata = 8'h04;
        core_wr = 1'b1; core_wdata = 8'h00;
        @(negedge clk);
        host_wr = 1'b0; core_wr = 1'b0;
        chk("R10 core wins (clear)", {24'd0, ctrl_rdata}, 32'h00);
        host_wr = 1'b1; host_wdata = 8'h00;
        core_wr = 1'b1; core_wdata = 8'h04;
        @(negedge clk);
        host_wr = 1'b0; core_wr = 1'b0;
        chk("R10 core wins (set)", {24'd0, ctrl_rdata}, 32'h04);
    endtask

    task automatic t_lbus;
        int n;
        int core_drop;
        do_reset(2'd2);
        chk("R8 no pulse after reset", {31'd0, local_bus_reset}, 32'd0);
        core_write(8'h20);
        chk("R9 pulse bit reads back", {24'd0, ctrl_rdata}, 32'h20);
        n = 0; core_drop = 0;
        while (local_bus_reset && n < 100) begin
            n++;
            if (!core_reset_n) core_drop++;
            @(negedge clk);
        end
        chk("R8 pulse length", n, 32'd16);
        chk("R8 core kept running", core_drop, 32'd0);
        core_write(8'h20);
        n = 0;
        for (int i = 0; i < 4; i++) begin
            if (local_bus_reset) n++;
            @(negedge clk);
        end
        if (local_bus_reset) n++;
        core_write(8'h20);
        while (local_bus_reset && n < 100) begin
            n++;
            @(negedge clk);
        end
        chk("R8 retrigger length", n, 32'd21);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_mode0();
        t_mode1();
        t_mode2();
        t_mode3();
        t_strap_hold();
        t_priority();
        t_lbus();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule